// File: doc/BRIEF.md
# SPI Master with Per-Word Slave Select

This block is a full-duplex SPI master. Each 16-bit transmit word is pushed into a small transmit queue together with an 8-bit slave-select pattern. The pattern travels with its word, so a select change takes effect at a frame boundary and never while earlier words are still going out. An internal frame signal is high for each transfer. It is spread over eight select lines, either one line per pattern bit (direct) or one line chosen by a 3-bit code (coded). All lines can be inverted.

The serial clock idles high. Data is sampled on the falling (leading) edge and changed on the rising (trailing) edge, most significant bit first. The clock period is a programmable number of system cycles. Setup and hold delays of one period surround every frame, and an idle gap of one period separates frames. When the next word carries a different pattern, the frame signal stays low for one extra period before that word starts. Each received word goes into a receive queue. The fill levels of both queues are visible, and a write into a full transmit queue is refused and flagged.

Top module: `spi_sel_master`

## Requirements
- R1: Each frame shifts 16 bits MSB first on `mosi`. The 16 bits sampled from `miso` on the falling edges of `sclk`, first sample as bit 15, form the received word.
- R2: `sclk` is high whenever no frame is active. Each frame has exactly 16 falling edges of `sclk`.
- R3: Let P = max(`cfg_div`, 2), L = floor(P/2) and H = P − L. The select lines are active for 2P + 16L + 15H cycles per frame. The first falling edge of `sclk` comes P cycles after they activate.
- R4: When the next queued word has the same pattern as the word just sent, the select lines are inactive for exactly P cycles between the two frames.
- R5: When the next queued word has a different pattern, the select lines are inactive for exactly 2P cycles between the two frames. The pattern in use never changes while a frame is active.
- R6: With `cfg_coded`=0 (direct mode), select line i is active during a frame exactly when bit i of that word's pattern is 1.
- R7: With `cfg_coded`=1 (coded mode), only the line numbered by pattern bits [2:0] is active during a frame. Pattern bits [7:3] are ignored.
- R8: With `cfg_invert`=1, active lines are driven 0 and inactive lines 1. With `cfg_invert`=0, active lines are 1 and inactive lines 0.
- R9: `tx_level` equals the number of queued transmit words. A write while `tx_level` equals the queue depth (4) stores nothing and raises `tx_err` for one cycle, on the cycle after the write.
- R10: `shift_done` pulses for one cycle in the first cycle the select lines are inactive after a frame. The received word is then added to the receive queue, or dropped if that queue already holds 4 words. `rx_data` shows the oldest word, `rx_rd` removes it, and `rx_level` gives the count.
- R11: `busy` is high while a frame is active or the transmit queue is not empty, and low otherwise.
- R12: After reset, `sclk` is 1, both levels are 0, `busy` is 0 and the select lines are at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 8 | SCLK period in system cycles (values below 2 act as 2) |
| cfg_coded | input | 1 | 1 selects coded mode, 0 selects direct mode |
| cfg_invert | input | 1 | Inverts all select lines |
| tx_wr | input | 1 | Writes one word and its pattern into the transmit queue |
| tx_data | input | 16 | Transmit word |
| tx_sel | input | 8 | Select pattern for this word |
| tx_err | output | 1 | Pulse: a write was refused because the queue was full |
| tx_level | output | 3 | Transmit queue fill level |
| rx_rd | input | 1 | Removes the oldest received word |
| rx_data | output | 16 | Oldest received word |
| rx_level | output | 3 | Receive queue fill level |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_o | output | 8 | Slave select lines |
| shift_done | output | 1 | Pulse at the end of each frame |
| busy | output | 1 | Frame active or words queued |

## Verification
The data path is driven with asymmetric words such as A5C3 against a different slave word on `miso`. This shows whether bit order and sampling edge are correct in both directions. Pairs of queued words with equal patterns and with different patterns separate the one-period gap from the two-period gap. They also show whether a pattern ever reaches a frame it does not belong to. Direct mode with inversion, and coded mode without inversion using a pattern whose upper bits are set, separate the two mappings and both polarities. Three divider settings check the cycle count formula: 0 (clamped to 2), an even value and an odd value. A burst of six writes at a slow clock fills the transmit queue, triggers a refusal and overflows the receive queue.

// File: rtl/spi_sel_pkg.sv
`timescale 1ns/1ps
package spi_sel_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL,
        ST_GAP
    } eng_state_e;
endpackage

// File: rtl/spi_sel_fifo.sv
`timescale 1ns/1ps
module spi_sel_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.lvl == LW'(DEPTH));
    assign empty   = (q.lvl == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        d = q;
        if (do_push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + AW'(1);
        if (do_pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + AW'(1);
        case ({do_push, do_pop})
            2'b10:   d.lvl = q.lvl + LW'(1);
            2'b01:   d.lvl = q.lvl - LW'(1);
            default: d.lvl = q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= din;
    end

    assign dout  = mem[q.rp];
    assign level = q.lvl;
endmodule

// File: rtl/spi_sel_engine.sv
`timescale 1ns/1ps
module spi_sel_engine
    import spi_sel_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SEL_W  = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              q_empty,
    input  logic [WORD_W-1:0] q_data,
    input  logic [SEL_W-1:0]  q_sel,
    output logic              q_pop,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              msls,
    output logic [SEL_W-1:0]  pat,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int BW = $clog2(WORD_W);

    typedef struct packed {
        eng_state_e        st;
        logic [DIV_W-1:0]  cnt;
        logic [BW-1:0]     bitn;
        logic [WORD_W-1:0] tsh;
        logic [WORD_W-1:0] rsh;
        logic [SEL_W-1:0]  pat;
        logic              sclk;
        logic              msls;
        logic              hold;
        logic              done;
    } eng_t;

    eng_t q, d;
    logic [DIV_W-1:0] per, lo_len, hi_len;
    logic launch;

    always_comb begin
        per    = (div < DIV_W'(2)) ? DIV_W'(2) : div;
        lo_len = per >> 1;
        hi_len = per - lo_len;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        launch = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (!q_empty) launch = 1'b1;
            end
            ST_LEAD, ST_HIGH: begin
                if (q.cnt == '0) begin
                    d.st   = ST_LOW;
                    d.sclk = 1'b0;
                    d.cnt  = lo_len - DIV_W'(1);
                    d.rsh  = {q.rsh[WORD_W-2:0], miso};
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            ST_LOW: begin
                if (q.cnt == '0) begin
                    d.sclk = 1'b1;
                    if (q.bitn == '0) begin
                        d.st  = ST_TRAIL;
                        d.cnt = per - DIV_W'(1);
                    end else begin
                        d.st   = ST_HIGH;
                        d.cnt  = hi_len - DIV_W'(1);
                        d.tsh  = {q.tsh[WORD_W-2:0], 1'b0};
                        d.bitn = q.bitn - BW'(1);
                    end
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            ST_TRAIL: begin
                if (q.cnt == '0) begin
                    d.msls = 1'b0;
                    d.done = 1'b1;
                    d.st   = ST_GAP;
                    d.cnt  = per - DIV_W'(1);
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            ST_GAP: begin
                if (q.cnt == '0) begin
                    if (q_empty) begin
                        d.st   = ST_IDLE;
                        d.hold = 1'b0;
                    end else if (q.hold || (q_sel == q.pat)) begin
                        launch = 1'b1;
                    end else begin
                        d.hold = 1'b1;
                        d.cnt  = per - DIV_W'(1);
                    end
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (launch) begin
            d.st   = ST_LEAD;
            d.cnt  = per - DIV_W'(1);
            d.bitn = BW'(WORD_W - 1);
            d.tsh  = q_data;
            d.pat  = q_sel;
            d.msls = 1'b1;
            d.sclk = 1'b1;
            d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign q_pop   = launch;
    assign sclk    = q.sclk;
    assign mosi    = q.tsh[WORD_W-1];
    assign msls    = q.msls;
    assign pat     = q.pat;
    assign done    = q.done;
    assign rx_word = q.rsh;
endmodule

// File: rtl/spi_sel_decode.sv
`timescale 1ns/1ps
module spi_sel_decode #(
    parameter int SEL_W = 8
) (
    input  logic             msls,
    input  logic [SEL_W-1:0] pat,
    input  logic             coded,
    input  logic             invert,
    output logic [SEL_W-1:0] sel_o
);
    localparam int CW = $clog2(SEL_W);

    for (genvar i = 0; i < SEL_W; i++) begin : g_line
        logic hit;
        assign hit      = coded ? (pat[CW-1:0] == CW'(i)) : pat[i];
        assign sel_o[i] = (msls & hit) ^ invert;
    end
endmodule

// File: rtl/spi_sel_master.sv
`timescale 1ns/1ps
module spi_sel_master #(
    parameter int WORD_W     = 16,
    parameter int SEL_W      = 8,
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_coded,
    input  logic              cfg_invert,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_data,
    input  logic [SEL_W-1:0]  tx_sel,
    output logic              tx_err,
    output logic [LVL_W-1:0]  tx_level,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_data,
    output logic [LVL_W-1:0]  rx_level,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [SEL_W-1:0]  sel_o,
    output logic              shift_done,
    output logic              busy
);
    localparam int ENT_W = WORD_W + SEL_W;

    logic [ENT_W-1:0]  tx_head;
    logic              tx_empty, tx_full, tx_pop;
    logic              rx_empty, rx_full;
    logic              msls;
    logic [SEL_W-1:0]  pat_cur;
    logic [WORD_W-1:0] rx_word;
    logic              err_d, err_q;

    spi_sel_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_wr),
        .pop   (tx_pop),
        .din   ({tx_sel, tx_data}),
        .dout  (tx_head),
        .empty (tx_empty),
        .full  (tx_full),
        .level (tx_level)
    );

    spi_sel_engine #(.WORD_W(WORD_W), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (cfg_div),
        .q_empty (tx_empty),
        .q_data  (tx_head[WORD_W-1:0]),
        .q_sel   (tx_head[ENT_W-1:WORD_W]),
        .q_pop   (tx_pop),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .msls    (msls),
        .pat     (pat_cur),
        .done    (shift_done),
        .rx_word (rx_word)
    );

    spi_sel_decode #(.SEL_W(SEL_W)) u_dec (
        .msls   (msls),
        .pat    (pat_cur),
        .coded  (cfg_coded),
        .invert (cfg_invert),
        .sel_o  (sel_o)
    );

    spi_sel_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (shift_done && !rx_full),
        .pop   (rx_rd && !rx_empty),
        .din   (rx_word),
        .dout  (rx_data),
        .empty (rx_empty),
        .full  (rx_full),
        .level (rx_level)
    );

    always_comb err_d = tx_wr && tx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign tx_err = err_q;
    assign busy   = msls || !tx_empty;
endmodule

// File: rtl/spi_sel_checker.sv
`timescale 1ns/1ps
module spi_sel_checker #(
    parameter int SEL_W      = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int LVL_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msls,
    input logic [SEL_W-1:0] pat,
    input logic             sclk,
    input logic             busy,
    input logic             shift_done,
    input logic             tx_wr,
    input logic             tx_err,
    input logic [LVL_W-1:0] tx_level,
    input logic             cfg_coded,
    input logic             cfg_invert,
    input logic [SEL_W-1:0] sel_o
);
    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LVL_W'(FIFO_DEPTH));

    a_r9_err_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_level == LVL_W'(FIFO_DEPTH)) |=> tx_err);

    a_r5_pattern_held: assert property (@(posedge clk) disable iff (!rst_n)
        (msls && $past(msls)) |-> (pat == $past(pat)));

    a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !msls |-> sclk);

    a_r11_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        msls |-> busy);

    a_r10_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        shift_done |-> (!msls && $past(msls)));

    a_r7_coded_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_coded && !cfg_invert) |-> $onehot0(sel_o));

    a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !msls |-> (sel_o == {SEL_W{cfg_invert}}));
endmodule

bind spi_sel_master spi_sel_checker #(
    .SEL_W(SEL_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msls       (msls),
    .pat        (pat_cur),
    .sclk       (sclk),
    .busy       (busy),
    .shift_done (shift_done),
    .tx_wr      (tx_wr),
    .tx_err     (tx_err),
    .tx_level   (tx_level),
    .cfg_coded  (cfg_coded),
    .cfg_invert (cfg_invert),
    .sel_o      (sel_o)
);

// File: tb/spi_sel_master_bench.sv
`timescale 1ns/1ps
module spi_sel_master_bench;
    localparam int WW = 16;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    cfg_div;
    logic          cfg_coded, cfg_invert;
    logic          tx_wr;
    logic [WW-1:0] tx_data;
    logic [SW-1:0] tx_sel;
    logic          tx_err;
    logic [2:0]    tx_level, rx_level;
    logic          rx_rd;
    logic [WW-1:0] rx_data;
    logic          sclk, mosi, miso;
    logic [SW-1:0] sel_o;
    logic          shift_done, busy;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    spi_sel_master u_spi_sel_master (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_coded(cfg_coded),
        .cfg_invert(cfg_invert), .tx_wr(tx_wr), .tx_data(tx_data), .tx_sel(tx_sel),
        .tx_err(tx_err), .tx_level(tx_level), .rx_rd(rx_rd), .rx_data(rx_data),
        .rx_level(rx_level), .sclk(sclk), .mosi(mosi), .miso(miso), .sel_o(sel_o),
        .shift_done(shift_done), .busy(busy)
    );

    // frame monitor and slave model, all at the falling clock edge
    int          nfr = 0;
    logic        act, prev_act = 1'b0, prev_sclk = 1'b1, seen_fall;
    int          cur_len, cur_lead, cur_falls, cur_gap = 0, bi;
    logic [15:0] cur_mw;
    int          f_len [64];
    int          f_lead [64];
    int          f_falls [64];
    int          f_gap [64];
    logic [15:0] f_mw [64];
    logic [7:0]  f_sel [64];
    logic        f_done [64];
    logic [15:0] slv [64];

    always @(negedge clk) begin
        act = (sel_o != {SW{cfg_invert}});
        if (!rst_n) begin
            miso = 1'b0;
        end else if (act && !prev_act) begin
            f_gap[nfr & 63] = cur_gap;
            f_sel[nfr & 63] = sel_o;
            cur_len   = 1;
            cur_lead  = sclk ? 1 : 0;
            cur_falls = 0;
            cur_mw    = '0;
            seen_fall = 1'b0;
            bi        = WW - 1;
            miso      = slv[nfr & 63][bi];
        end else if (act) begin
            cur_len++;
            if (prev_sclk && !sclk) begin
                cur_falls++;
                cur_mw    = {cur_mw[14:0], mosi};
                seen_fall = 1'b1;
            end
            if (!seen_fall && sclk) cur_lead++;
            if (!prev_sclk && sclk && bi > 0) begin
                bi--;
                miso = slv[nfr & 63][bi];
            end
        end else if (prev_act) begin
            f_len[nfr & 63]   = cur_len;
            f_lead[nfr & 63]  = cur_lead;
            f_falls[nfr & 63] = cur_falls;
            f_mw[nfr & 63]    = cur_mw;
            f_done[nfr & 63]  = shift_done;
            nfr++;
            cur_gap = 1;
        end else begin
            cur_gap++;
        end
        prev_act  = act;
        prev_sclk = sclk;
    end

    task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expected);
        vectors++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    function automatic int exp_len(input int dv);
        int p, l;
        p = (dv < 2) ? 2 : dv;
        l = p / 2;
        return 2 * p + 16 * l + 15 * (p - l);
    endfunction

    task automatic push(input logic [15:0] dat, input logic [7:0] pt);
        @(negedge clk);
        tx_wr = 1'b1; tx_data = dat; tx_sel = pt;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        while (nfr < target) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pop_rx(input string tag, input logic [15:0] expv);
        chk(tag, 32'(rx_data), 32'(expv));
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 sclk", 32'(sclk), 1);
        chk("R12 tx_level", 32'(tx_level), 0);
        chk("R12 rx_level", 32'(rx_level), 0);
        chk("R12 busy", 32'(busy), 0);
        chk("R12 R8 sel idle", 32'(sel_o), 32'hFF);
    endtask

    task automatic t_direct();
        int b = nfr;
        slv[b & 63] = 16'h3C5A;
        push(16'hA5C3, 8'h04);
        repeat (5) @(negedge clk);
        chk("R11 busy during frame", 32'(busy), 1);
        wait_frames(b + 1);
        chk("R1 mosi word", 32'(f_mw[b & 63]), 32'hA5C3);
        chk("R2 falling edges", 32'(f_falls[b & 63]), 16);
        chk("R3 active length", 32'(f_len[b & 63]), 32'(exp_len(4)));
        chk("R3 lead delay", 32'(f_lead[b & 63]), 4);
        chk("R6 R8 direct select", 32'(f_sel[b & 63]), 32'hFB);
        chk("R10 done at fall", 32'(f_done[b & 63]), 1);
        wait_idle();
        chk("R11 busy after", 32'(busy), 0);
        chk("R10 rx_level", 32'(rx_level), 1);
        pop_rx("R1 rx word", 16'h3C5A);
        chk("R10 rx_level drained", 32'(rx_level), 0);
    endtask

    task automatic t_same();
        int b = nfr;
        slv[b & 63] = 16'h0F0F; slv[(b + 1) & 63] = 16'h8001;
        push(16'h1357, 8'h81);
        push(16'hFFFE, 8'h81);
        wait_frames(b + 2);
        chk("R4 same-pattern gap", 32'(f_gap[(b + 1) & 63]), 4);
        chk("R1 second word", 32'(f_mw[(b + 1) & 63]), 32'hFFFE);
        chk("R6 select frame 2", 32'(f_sel[(b + 1) & 63]), 32'h7E);
        wait_idle();
        pop_rx("R10 rx first", 16'h0F0F);
        pop_rx("R10 rx second", 16'h8001);
    endtask

    task automatic t_change();
        int b = nfr;
        slv[b & 63] = 16'h1111; slv[(b + 1) & 63] = 16'h2222;
        push(16'hC001, 8'h02);
        push(16'h700E, 8'h10);
        wait_frames(b + 2);
        chk("R5 changed-pattern gap", 32'(f_gap[(b + 1) & 63]), 8);
        chk("R5 select frame 1", 32'(f_sel[b & 63]), 32'hFD);
        chk("R5 select frame 2", 32'(f_sel[(b + 1) & 63]), 32'hEF);
        chk("R1 word frame 2", 32'(f_mw[(b + 1) & 63]), 32'h700E);
        wait_idle();
        pop_rx("R10 rx first", 16'h1111);
        pop_rx("R10 rx second", 16'h2222);
    endtask

    task automatic t_coded();
        int b = nfr;
        @(negedge clk);
        cfg_coded = 1'b1; cfg_invert = 1'b0;
        @(negedge clk);
        chk("R8 idle non-inverted", 32'(sel_o), 0);
        slv[b & 63] = 16'hFEDC;
        push(16'h1234, 8'hF5);
        wait_frames(b + 1);
        chk("R7 coded select", 32'(f_sel[b & 63]), 32'h20);
        chk("R1 coded word", 32'(f_mw[b & 63]), 32'h1234);
        wait_idle();
        pop_rx("R1 coded rx", 16'hFEDC);
        cfg_coded = 1'b0; cfg_invert = 1'b1;
    endtask

    task automatic t_div();
        int b = nfr;
        cfg_div = 8'd0;
        slv[b & 63] = 16'h0001;
        push(16'h8000, 8'h01);
        wait_frames(b + 1);
        chk("R3 length div0", 32'(f_len[b & 63]), 32'(exp_len(0)));
        wait_idle();
        pop_rx("R1 rx div0", 16'h0001);
        cfg_div = 8'd5;
        slv[(b + 1) & 63] = 16'hBEEF;
        push(16'h6666, 8'h01);
        wait_frames(b + 2);
        chk("R3 length div5", 32'(f_len[(b + 1) & 63]), 32'(exp_len(5)));
        chk("R3 lead div5", 32'(f_lead[(b + 1) & 63]), 5);
        chk("R1 word div5", 32'(f_mw[(b + 1) & 63]), 32'h6666);
        wait_idle();
        pop_rx("R1 rx div5", 16'hBEEF);
        cfg_div = 8'd4;
    endtask

    task automatic t_overflow();
        int b = nfr;
        cfg_div = 8'd20;
        for (int i = 0; i < 6; i++) slv[(b + i) & 63] = 16'(16'h1000 + i);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            tx_wr = 1'b1; tx_data = 16'(16'hA000 + i); tx_sel = 8'h01;
        end
        @(negedge clk);
        chk("R9 level full", 32'(tx_level), 4);
        tx_data = 16'hDEAD;
        @(negedge clk);
        tx_wr = 1'b0;
        chk("R9 tx_err pulse", 32'(tx_err), 1);
        chk("R9 level unchanged", 32'(tx_level), 4);
        chk("R11 busy queued", 32'(busy), 1);
        @(negedge clk);
        chk("R9 tx_err single", 32'(tx_err), 0);
        wait_frames(b + 5);
        wait_idle();
        chk("R9 refused not sent", 32'(nfr), 32'(b + 5));
        chk("R9 last word", 32'(f_mw[(b + 4) & 63]), 32'hA004);
        chk("R10 rx full", 32'(rx_level), 4);
        for (int i = 0; i < 4; i++) pop_rx("R10 rx order", 16'(16'h1000 + i));
        chk("R10 rx drop", 32'(rx_level), 0);
        cfg_div = 8'd4;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_div = 8'd4; cfg_coded = 1'b0; cfg_invert = 1'b1;
        tx_wr = 1'b0; tx_data = '0; tx_sel = '0; rx_rd = 1'b0;
        for (int i = 0; i < 64; i++) slv[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_same();
        t_change();
        t_coded();
        t_div();
        t_overflow();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule